// File: doc/BRIEF.md
# Programmable I2C SCL Clock Generator

This block turns a fast peripheral clock into the SCL timing of an I2C master. A small prescaler first divides the peripheral clock by one to four to form an internal tick. The bus clock period is then counted in internal ticks as a base of twenty, plus eight per step of a six-bit period field, plus a fixed number of compensation ticks. The compensation ticks stand for the time the line spends rising, falling and passing through internal delay. That count is a design parameter, computed by the integrator from the internal clock rate and roughly 285 ns.

Each period opens with a low phase. During the low phase the block pulls SCL down, and its length is half of the base-plus-period ticks. The block then releases the line and waits until the synchronized SCL input reads high. Only then does it count the high phase, which is the other half plus the compensation ticks. Because of this wait, a slave that stretches the clock by holding SCL low simply delays the high phase. Two one-cycle strobes mark the first cycle of each low phase and the first counted cycle of each high phase, so that a byte engine can shift data on them.

Software writes both fields through one 8-bit clock-control word. A new value is held aside and takes effect when the next period begins. When the generator is disabled, the SCL line is left released. The integrator must choose settings that keep the internal tick below 20 MHz and the resulting bus rate at or below the target, which is 100 kHz by default.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is asserted, or on any cycle after a clock edge at which `enable` was low, `scl_drive_low`, `phase_lo_stb` and `phase_hi_stb` are all 0.
- R2: In the clock-control word, bits [1:0] select the prescale divisor (divide by value+1) and bits [7:2] hold the period field P.
- R3: Each low phase holds `scl_drive_low` at 1 for exactly (10 + 4*P) * (prescale+1) peripheral clock cycles.
- R4: Each high phase lasts exactly (10 + 4*P + COMP_CYCLES) * (prescale+1) cycles, counted from the `phase_hi_stb` cycle up to the next `phase_lo_stb` cycle. The full period in internal ticks is therefore 20 + 8*P + COMP_CYCLES.
- R5: After the line is released, the high phase starts only after the synchronized `scl_in` reads high. The released-to-high gap is SYNC_STAGES + 1 cycles, plus one cycle for every cycle that a slave holds the line low beyond the release.
- R6: A clock-control write made during a period does not change that period; it governs the next period and those after it.
- R7: `phase_lo_stb` is high only on the first cycle of a low phase, with `scl_drive_low` at 1. `phase_hi_stb` is high only on the first counted high cycle. The two are never high together.
- R8: On the cycle after the first clock edge at which `enable` is seen high, the generator is in a low phase with `phase_lo_stb` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low parks it with SCL released |
| cfg_wr | input | 1 | Write strobe for the clock-control word |
| cfg_wdata | input | CDF_W+SCGD_W | Clock-control word: period field above the prescale field |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low (open-drain), 0 releases it |
| phase_lo_stb | output | 1 | One-cycle mark at the start of each low phase |
| phase_hi_stb | output | 1 | One-cycle mark at the start of each counted high phase |

## Verification
The hardest situations to reach from the ports are a configuration write that arrives partway through a running period, and a slave stretching the clock. The bench models the open-drain line, with SCL released except when the block or a simulated slave pulls it. It runs a sequence of configurations, among them the largest period field and the largest divisor. The bench then counts how long each window lasts: the low phase, the released-to-high gap, and the high phase. To reach the write-during-period case, it writes a new word during the low phase of the second period. It expects that period to keep the old timing and the periods after it to use the new timing. For stretching, the simulated slave keeps the line low for several cycles after release, and the bench checks that the gap grows by exactly that amount.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Internal ticks spent driving SCL low: half of the base plus period term.
  function automatic int unsigned low_ticks(input int unsigned period_field);
    return 10 + 4 * period_field;
  endfunction

  // Internal ticks counted with SCL high: the other half plus compensation.
  function automatic int unsigned high_ticks(input int unsigned period_field,
                                             input int unsigned comp);
    return 10 + 4 * period_field + comp;
  endfunction

endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];

endmodule

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] divsel,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // One internal tick every divsel+1 peripheral cycles, aligned to restart.
  assign tick = (cnt_q == divsel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || tick)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
  import sclgen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             line_high,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [CNT_W-1:0] hi_len,
  output phase_e           state,
  output logic             enter_low,
  output logic             enter_high,
  output logic             lo_stb,
  output logic             hi_stb
);

  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_last, hi_last;

  assign lo_last = lo_len - 1'b1;
  assign hi_last = hi_len - 1'b1;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    enter_low  = 1'b0;
    enter_high = 1'b0;
    if (!enable) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          st_d      = PH_LOW;
          cnt_d     = '0;
          enter_low = 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            if (cnt_q == lo_last) begin
              st_d  = PH_WAIT;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (line_high) begin
            st_d       = PH_HIGH;
            cnt_d      = '0;
            enter_high = 1'b1;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            if (cnt_q == hi_last) begin
              st_d      = PH_LOW;
              cnt_d     = '0;
              enter_low = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      lo_stb <= 1'b0;
      hi_stb <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lo_stb <= enter_low;
      hi_stb <= enter_high;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import sclgen_pkg::*;
#(
  parameter int CDF_W       = 2,
  parameter int SCGD_W      = 6,
  parameter int COMP_CYCLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    cfg_wr,
  input  logic [CDF_W+SCGD_W-1:0] cfg_wdata,
  input  logic                    scl_in,
  output logic                    scl_drive_low,
  output logic                    phase_lo_stb,
  output logic                    phase_hi_stb
);

  localparam int CFG_W   = CDF_W + SCGD_W;
  localparam int MAX_LEN = 10 + 4 * ((1 << SCGD_W) - 1) + COMP_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CFG_W-1:0] pend_q, pend_next, act_q;
  logic [CNT_W-1:0] lo_len, hi_len;
  logic             tick, line_high, enter_low, enter_high;
  phase_e           state;

  // Held-aside word; the live copy is refreshed only when a period opens.
  assign pend_next = cfg_wr ? cfg_wdata : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_next;
      if (enter_low) act_q <= pend_next;
    end
  end

  assign lo_len = CNT_W'(low_ticks(32'(act_q[CFG_W-1:CDF_W])));
  assign hi_len = CNT_W'(high_ticks(32'(act_q[CFG_W-1:CDF_W]), 32'(COMP_CYCLES)));

  sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (line_high)
  );

  sclgen_prescaler #(.DIV_W(CDF_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (enter_low | enter_high),
    .divsel  (act_q[CDF_W-1:0]),
    .tick    (tick)
  );

  sclgen_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (tick),
    .line_high  (line_high),
    .lo_len     (lo_len),
    .hi_len     (hi_len),
    .state      (state),
    .enter_low  (enter_low),
    .enter_high (enter_high),
    .lo_stb     (phase_lo_stb),
    .hi_stb     (phase_hi_stb)
  );

  assign scl_drive_low = (state == PH_LOW);

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk
  import sclgen_pkg::*;
#(
  parameter int CDF_W  = 2,
  parameter int SCGD_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic                    scl_drive_low,
  input logic                    lo_stb,
  input logic                    hi_stb,
  input logic                    line_high,
  input logic [CDF_W+SCGD_W-1:0] act_cfg
);

  localparam int CFG_W = CDF_W + SCGD_W;

  logic [15:0] lo_run;
  logic [15:0] lo_expect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lo_run <= '0;
    else if (scl_drive_low) lo_run <= lo_run + 16'd1;
    else                    lo_run <= '0;
  end

  assign lo_expect = 16'(low_ticks(32'(act_cfg[CFG_W-1:CDF_W])) *
                         (32'(act_cfg[CDF_W-1:0]) + 1));

  assert_off_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !lo_stb && !hi_stb));

  assert_low_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && $past(enable)) |-> (lo_run == lo_expect));

  assert_high_after_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb |-> ($past(line_high) && !scl_drive_low));

  assert_cfg_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg != $past(act_cfg)) |-> lo_stb);

  assert_lo_stb_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_stb |-> scl_drive_low);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_stb && hi_stb));

  assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> lo_stb);

endmodule

bind scl_clkgen scl_clkgen_chk #(.CDF_W(CDF_W), .SCGD_W(SCGD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .scl_drive_low (scl_drive_low),
  .lo_stb        (phase_lo_stb),
  .hi_stb        (phase_hi_stb),
  .line_high     (line_high),
  .act_cfg       (act_q)
);

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;

  localparam int TB_COMP = 3;
  localparam int TB_SYNC = 2;

  typedef struct { int lo; int hi; int gap; } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, lo_stb, hi_stb;

  int total = 0;
  int bad = 0;
  int stretch = 0;
  int lo_seen = 0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  // Open-drain line: released unless the block or a stretching slave pulls it.
  assign scl_in = !scl_drive_low && !hold;

  scl_clkgen #(.COMP_CYCLES(TB_COMP), .SYNC_STAGES(TB_SYNC)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .phase_lo_stb  (lo_stb),
    .phase_hi_stb  (hi_stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected timing restated from the period formula (R2 field layout).
  function automatic item_t expect_item(input int cdf, input int scgd, input int s);
    item_t e;
    int full_p;
    full_p = 20 + 8 * scgd + TB_COMP;
    e.lo   = (cdf + 1) * ((20 + 8 * scgd) / 2);
    e.hi   = (cdf + 1) * full_p - e.lo;
    e.gap  = TB_SYNC + 1 + s;
    return e;
  endfunction

  // Monitor: measures every completed period and pops the scoreboard.
  bit inper = 0, seen_hi = 0, prev_drv = 0;
  int lo_c = 0, hi_c = 0, gap_c = 0, hold_cnt = 0;

  always @(negedge clk) begin
    if (prev_drv && !scl_drive_low) hold_cnt = stretch;
    else if (hold_cnt > 0)          hold_cnt--;
    hold = (hold_cnt > 0);
    prev_drv = scl_drive_low;
    if (!enable || !rst_n) begin
      inper   = 0;
      lo_seen = 0;
    end else begin
      if (lo_stb) begin
        if (inper && seen_hi) begin
          if (sb_q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R6 unexpected period actual=1 expected=0");
          end else begin
            item_t e;
            e = sb_q.pop_front();
            chk("R2/R3 low phase cycles", lo_c, e.lo);
            chk("R4 high phase cycles", hi_c, e.hi);
            chk("R5 release-to-high gap", gap_c, e.gap);
          end
        end
        inper   = 1;
        seen_hi = 0;
        lo_c    = 0;
        hi_c    = 0;
        gap_c   = 0;
        lo_seen++;
      end
      if (inper) begin
        if (hi_stb) seen_hi = 1;
        if (scl_drive_low) lo_c++;
        else if (seen_hi)  hi_c++;
        else               gap_c++;
      end
    end
  end

  task automatic write_cfg(input int cdf, input int scgd);
    @(negedge clk); #2;
    cfg_wr    = 1'b1;
    cfg_wdata = 8'((scgd << 2) | cdf);
    @(negedge clk); #2;
    cfg_wr    = 1'b0;
  endtask

  task automatic start_gen();
    @(negedge clk); #2;
    enable = 1'b1;
    @(negedge clk);
    chk("R8 low strobe after enable", int'(lo_stb), 1);
    chk("R8 drives low after enable", int'(scl_drive_low), 1);
  endtask

  task automatic stop_gen();
    @(negedge clk); #2;
    enable = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 released when disabled", int'(scl_drive_low), 0);
      chk("R1 no strobes when disabled", int'(lo_stb | hi_stb), 0);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic run_cfg(input int cdf, input int scgd, input int n, input int s);
    stretch = s;
    write_cfg(cdf, scgd);
    for (int i = 0; i < n; i++) sb_q.push_back(expect_item(cdf, scgd, s));
    start_gen();
    drain();
    stop_gen();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset releases line", int'(scl_drive_low), 0);
    chk("R1 reset low strobe", int'(lo_stb), 0);
    chk("R1 reset high strobe", int'(hi_stb), 0);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(scl_drive_low), 0);

    // R3 R4: several field patterns, smallest period and largest period/divisor.
    run_cfg(0, 0, 2, 0);
    run_cfg(1, 5, 2, 0);
    run_cfg(3, 2, 2, 0);
    run_cfg(2, 63, 1, 0);
    run_cfg(3, 63, 1, 0);

    // R5: slave holds SCL low after release.
    run_cfg(0, 1, 2, 7);
    run_cfg(2, 0, 1, 1);

    // R6: write during period two takes effect from period three.
    stretch = 0;
    write_cfg(0, 1);
    sb_q.push_back(expect_item(0, 1, 0));
    sb_q.push_back(expect_item(0, 1, 0));
    sb_q.push_back(expect_item(1, 3, 0));
    sb_q.push_back(expect_item(1, 3, 0));
    start_gen();
    while (lo_seen < 2) @(negedge clk);
    write_cfg(1, 3);
    drain();
    stop_gen();

    finish_run();
  end

endmodule